// File: doc/BRIEF.md
# Frame Base Update Interrupt Unit

This unit sits on the register side of a raster display controller. Software programs the start address of the next frame buffer through a small register port. It may do so at any moment. The value is held in a shadow register and marked pending. It reaches the live address seen by the pixel fetch logic only when the timing generator signals the start of a frame. That handover is the event that raises the frame-switch interrupt. Software therefore learns exactly when a buffer it wrote has become the displayed one, and can then reuse the buffer shown before it.

The interrupt side has four registers:
- a raw status word;
- an enable mask;
- a masked status word, which is the raw status ANDed with the enable mask;
- a write-one-to-clear register.

The interrupt line is a registered OR of the masked status bits. All registers are word-addressed. Reads return data one cycle after the read strobe.

Top module: `fbase_update_irq`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: the shadow address, the live address, the pending flag, the enable bit, the raw status and the interrupt output.
- R2: A write to offset 0 stores the written word in the shadow address with bits [1:0] forced to zero, and sets the pending flag. Offset 0 reads back the shadow address. The live address (output `fetch_base`, also readable at offset 1) does not change on that write.
- R3: On a cycle where `frame_start` is high and the pending flag is set, the live address takes the shadow value at that clock edge and the pending flag clears. The pending flag reads as bit 0 of offset 6.
- R4: A `frame_start` pulse while nothing is pending leaves the live address and the raw status unchanged.
- R5: The handover in R3 sets raw status bit 0, the frame-switch source. The raw status reads at offset 3.
- R6: Offset 4 reads raw status AND enable. The enable bit is bit 0 of offset 2, and both are readable. A zero read of offset 4 means no interrupt is pending.
- R7: A write to offset 5 clears every raw status bit that is one in the written word and leaves the others. Offset 5 reads as zero.
- R8: When a clear and a handover land in the same cycle, the raw status bit ends up set.
- R9: `irq` is a register loaded each cycle with the OR of the masked status bits. It follows them with one cycle of delay, and it stays low while the enable bit is zero.
- R10: A base write in the same cycle as a handover sends the previous shadow value to the live address. The new value stays in the shadow, still pending, for the next frame.
- R11: `reg_rdata` is registered. It changes only in the cycle after `reg_rd` and holds its value otherwise. Offset 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame start pulse from the timing generator |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| fetch_base | output | DATA_W | Live frame base address for the fetch logic |
| irq | output | 1 | Registered interrupt request |

## Verification
Some properties are checked by assertions on every clock cycle:
- the live address moves only at a handover, and then takes the shadow value;
- a handover always leaves the raw bit set, even when a clear arrives in the same cycle;
- a zero enable forces `irq` low;
- both address registers stay word aligned.

Other properties only the bench scenarios can show. These are the read-back values at each offset, the one-cycle read latency and hold, the effect of clear masks with and without bit 0, and the write-during-handover ordering. The bench shows them by comparing every cycle against a reference model kept in the bench, under both directed and random register traffic.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  // Word offsets of the register port
  localparam int unsigned OFS_BASE_NEXT = 0;
  localparam int unsigned OFS_BASE_LIVE = 1;
  localparam int unsigned OFS_IRQ_EN    = 2;
  localparam int unsigned OFS_IRQ_RAW   = 3;
  localparam int unsigned OFS_IRQ_MSK   = 4;
  localparam int unsigned OFS_IRQ_CLR   = 5;
  localparam int unsigned OFS_PEND      = 6;
  // Interrupt source index of the frame-switch event
  localparam int unsigned SRC_SWITCH    = 0;
endpackage

// File: rtl/fbu_base_buf.sv
module fbu_base_buf #(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              base_wr,
  input  logic [DATA_W-1:0] base_wdata,
  output logic [DATA_W-1:0] shadow_q,
  output logic [DATA_W-1:0] active_q,
  output logic              pending_q,
  output logic              take
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W)'((1 << ALIGN_BITS) - 1));

  assign take = frame_start & pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= '0;
      active_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (take)
        active_q <= shadow_q;
      if (base_wr) begin
        shadow_q  <= base_wdata & ALIGN_MASK;
        pending_q <= 1'b1;
      end else if (take) begin
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbu_irq_ctrl.sv
module fbu_irq_ctrl #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] masked,
  output logic            irq_q
);
  assign masked = raw_q & en_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)
        raw_q[i] <= 1'b0;
      else if (set_vec[i])
        raw_q[i] <= 1'b1;
      else if (clr_wr && clr_mask[i])
        raw_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr)
        en_q <= en_wdata;
      irq_q <= |masked;
    end
  end
endmodule

// File: rtl/fbu_read_port.sv
module fbu_read_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int NSRC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] shadow,
  input  logic [DATA_W-1:0] active,
  input  logic [NSRC-1:0]   en,
  input  logic [NSRC-1:0]   raw,
  input  logic [NSRC-1:0]   masked,
  input  logic              pending,
  output logic [DATA_W-1:0] rdata
);
  import fbu_pkg::*;
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(OFS_BASE_NEXT)) sel = shadow;
    if (addr == ADDR_W'(OFS_BASE_LIVE)) sel = active;
    if (addr == ADDR_W'(OFS_IRQ_EN))    sel = DATA_W'(en);
    if (addr == ADDR_W'(OFS_IRQ_RAW))   sel = DATA_W'(raw);
    if (addr == ADDR_W'(OFS_IRQ_MSK))   sel = DATA_W'(masked);
    if (addr == ADDR_W'(OFS_PEND))      sel = DATA_W'(pending);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= sel;
  end
endmodule

// File: rtl/fbase_update_irq.sv
module fbase_update_irq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] fetch_base,
  output logic              irq
);
  import fbu_pkg::*;
  localparam int NSRC = 1;

  logic [DATA_W-1:0] base_shadow;
  logic [DATA_W-1:0] base_live;
  logic              base_pend;
  logic              base_take;
  logic [NSRC-1:0]   st_raw, st_en, st_msk, set_vec;
  logic              wr_base, wr_en, wr_clr;

  assign wr_base = reg_wr && (reg_addr == ADDR_W'(OFS_BASE_NEXT));
  assign wr_en   = reg_wr && (reg_addr == ADDR_W'(OFS_IRQ_EN));
  assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(OFS_IRQ_CLR));

  always_comb begin
    set_vec = '0;
    set_vec[SRC_SWITCH] = base_take;
  end

  fbu_base_buf #(.DATA_W(DATA_W), .ALIGN_BITS(2)) u_base (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .base_wr(wr_base), .base_wdata(reg_wdata),
    .shadow_q(base_shadow), .active_q(base_live),
    .pending_q(base_pend), .take(base_take)
  );

  fbu_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .en_wr(wr_en), .en_wdata(reg_wdata[NSRC-1:0]),
    .clr_wr(wr_clr), .clr_mask(reg_wdata[NSRC-1:0]),
    .raw_q(st_raw), .en_q(st_en), .masked(st_msk), .irq_q(irq)
  );

  fbu_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSRC(NSRC)) u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr),
    .shadow(base_shadow), .active(base_live), .en(st_en),
    .raw(st_raw), .masked(st_msk), .pending(base_pend),
    .rdata(reg_rdata)
  );

  assign fetch_base = base_live;
endmodule

// File: rtl/fbase_update_irq_chk.sv
module fbase_update_irq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              pending,
  input logic              clr_wr,
  input logic [DATA_W-1:0] shadow,
  input logic [DATA_W-1:0] live,
  input logic              raw0,
  input logic              en0,
  input logic              irq
);
  // R3: handover copies the shadow into the live address
  a_r3_live_takes_shadow: assert property (@(posedge clk) disable iff (rst)
    (frame_start && pending) |=> (live == $past(shadow)));
  // R4: without a handover the live address holds
  a_r4_live_holds: assert property (@(posedge clk) disable iff (rst)
    !(frame_start && pending) |=> $stable(live));
  // R5: handover leaves the frame-switch bit set
  a_r5_switch_sets_raw: assert property (@(posedge clk) disable iff (rst)
    (frame_start && pending) |=> raw0);
  // R8: set wins over a simultaneous clear
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (frame_start && pending && clr_wr) |=> raw0);
  // R9: disabled source keeps the line low
  a_r9_masked_low: assert property (@(posedge clk) disable iff (rst)
    !en0 |=> !irq);
  // R2: both addresses stay word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    (shadow[1:0] == 2'b00) && (live[1:0] == 2'b00));
endmodule

bind fbase_update_irq fbase_update_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .pending(base_pend),
  .clr_wr(wr_clr), .shadow(base_shadow), .live(base_live),
  .raw0(st_raw[0]), .en0(st_en[0]), .irq(irq)
);

// File: tb/fbase_update_irq_bench.sv
module fbase_update_irq_bench;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata, fetch_base;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] m_shadow = '0, m_live = '0, m_rdata = '0;
  logic          m_pend = 0, m_raw = 0, m_en = 0, m_irq = 0;

  always #2 clk = ~clk;

  fbase_update_irq #(.DATA_W(DW), .ADDR_W(AW)) u_fbase_update_irq (
    .clk(clk), .rst(rst), .frame_start(frame_start), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fetch_base(fetch_base), .irq(irq)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
    case (a)
      3'd0: return m_shadow;
      3'd1: return m_live;
      3'd2: return DW'(m_en);
      3'd3: return DW'(m_raw);
      3'd4: return DW'(m_raw & m_en);
      3'd6: return DW'(m_pend);
      default: return '0;
    endcase
  endfunction

  // one clock: drive at negedge, advance model, compare after the edge
  task automatic cyc(string tag, logic fs, logic wr, logic rd,
                     logic [AW-1:0] a, logic [DW-1:0] wd);
    logic take;
    logic [DW-1:0] n_shadow, n_live, n_rdata;
    logic n_pend, n_raw, n_en, n_irq;
    @(negedge clk);
    frame_start = fs; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    take     = fs && m_pend;
    n_live   = take ? m_shadow : m_live;
    n_shadow = (wr && a == 0) ? (wd & ~32'h3) : m_shadow;
    n_pend   = (wr && a == 0) ? 1'b1 : (take ? 1'b0 : m_pend);
    n_raw    = take ? 1'b1 : ((wr && a == 5 && wd[0]) ? 1'b0 : m_raw);
    n_en     = (wr && a == 2) ? wd[0] : m_en;
    n_irq    = m_raw & m_en;
    n_rdata  = rd ? model_read(a) : m_rdata;
    @(posedge clk); #1;
    m_live = n_live; m_shadow = n_shadow; m_pend = n_pend;
    m_raw = n_raw; m_en = n_en; m_irq = n_irq; m_rdata = n_rdata;
    chk({tag, " fetch_base"}, fetch_base, m_live);
    chk({tag, " irq"}, DW'(irq), DW'(m_irq));
    chk({tag, " rdata"}, reg_rdata, m_rdata);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, '0);
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
    cyc(tag, 0, 0, 1, a, '0);
    chk({tag, " direct"}, reg_rdata, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    chk("R1 fetch_base", fetch_base, '0);
    chk("R1 irq", DW'(irq), '0);
    for (int a = 0; a < 8; a++) rd_chk("R1 read", AW'(a), '0);
    // R2: aligned shadow write, live untouched
    cyc("R2", 0, 1, 0, 0, 32'h1000_0007);
    rd_chk("R2 shadow", 0, 32'h1000_0004);
    chk("R2 live", fetch_base, '0);
    rd_chk("R3 pending set", 6, 32'd1);
    // R3/R5: handover
    cyc("R3", 1, 0, 0, 0, '0);
    chk("R3 live", fetch_base, 32'h1000_0004);
    rd_chk("R3 pending clear", 6, 32'd0);
    rd_chk("R5 raw", 3, 32'd1);
    // R6/R9: masked with enable off
    rd_chk("R6 masked off", 4, 32'd0);
    chk("R9 irq off", DW'(irq), '0);
    cyc("R6", 0, 1, 0, 2, 32'd1);
    rd_chk("R6 masked on", 4, 32'd1);
    chk("R9 irq on", DW'(irq), 32'd1);
    // R7: clear with zero mask keeps, with bit 0 clears
    cyc("R7", 0, 1, 0, 5, 32'hFFFF_FFFE);
    rd_chk("R7 keep", 3, 32'd1);
    cyc("R7", 0, 1, 0, 5, 32'd1);
    rd_chk("R7 cleared", 3, 32'd0);
    rd_chk("R11 clr reads zero", 5, 32'd0);
    idle("R9");
    chk("R9 irq drops", DW'(irq), '0);
    // R4: frame start with nothing pending
    cyc("R4", 1, 0, 0, 0, '0);
    chk("R4 live", fetch_base, 32'h1000_0004);
    rd_chk("R4 raw", 3, 32'd0);
    // R8: clear and set same cycle
    cyc("R8", 0, 1, 0, 0, 32'h2000_0000);
    cyc("R8", 1, 1, 0, 5, 32'd1);
    rd_chk("R8 raw", 3, 32'd1);
    // R10: base write during handover
    cyc("R10", 0, 1, 0, 0, 32'h3000_0010);
    cyc("R10", 1, 1, 0, 0, 32'h4000_0020);
    chk("R10 live", fetch_base, 32'h3000_0010);
    rd_chk("R10 shadow", 0, 32'h4000_0020);
    rd_chk("R10 pending", 6, 32'd1);
    // R11: hold without read strobe, offset 7 zero
    idle("R11 hold");
    chk("R11 hold", reg_rdata, 32'd1);
    rd_chk("R11 unmapped", 7, 32'd0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic fs, wr, rd;
      logic [AW-1:0] a;
      fs = ($urandom % 8) == 0;
      wr = ($urandom % 3) == 0;
      rd = ($urandom % 2) == 0;
      a  = AW'($urandom % 8);
      cyc("RND", fs, wr, rd, a, $urandom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule